// File: doc/BRIEF.md
# SMBus Strap-Latched Slave Address Matcher

This block gives an SMBus slave its 7-bit address and recognises that address on the bus. In the first clock after reset is released it samples four strap pins and forms the address as 0x18 plus the strap value, so one of sixteen addresses from 0x18 to 0x27 is selected. If the bypass input is high at that moment, the straps are ignored and the address is fixed at 0x18. After that the address does not change until the next reset.

A fast system clock oversamples SCL and SDA through two-flop synchronisers. On this clock the block detects START and STOP conditions. It shifts in the first byte after every START, MSB first, on rising SCL edges. It then compares bits 7:1 of that byte with the latched address. On a match it emits a one-cycle pulse and a direction flag, and it holds SDA low for the acknowledge clock. It then remains busy until a STOP. On a mismatch it stays silent until the next START.

Top module: `smb_strap_addr_match`

## Requirements
- R1: The strap and bypass inputs are sampled once, in the first clock with rst_n high. Later changes on them do not alter the address that is matched.
- R2: With bypass low at sampling time, the device address is 0x18 plus the 4-bit strap value. An address byte equal to {address, direction} matches, and any other 7-bit value does not.
- R3: With bypass high at sampling time, the device address is 0x18 (write byte 0x30) whatever the strap value.
- R4: Bit 0 of the address byte is the direction. rw_dir_o is 1 for a read and 0 for a write, and it is valid while addr_match_o is high.
- R5: The address byte is exactly 8 bits, sent MSB first. SDA is sampled on each rising SCL edge.
- R6: On a match, sda_pull_o (1 = drive SDA low) rises after the SCL falling edge that ends bit 8. It is high during the ninth SCL high phase, and it is low again after the falling edge that ends bit 9.
- R7: On a mismatch there is no addr_match_o pulse and no pull. Further SCL bits are ignored until the next START, even if they would form a matching byte.
- R8: A repeated START during a partly received byte restarts address capture from bit 7.
- R9: busy_o goes high with a match and stays high across later bytes. A STOP (SDA rising while SCL is high) clears it and returns the block to idle.
- R10: addr_match_o is high for exactly one clock cycle per matched address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_i | input | 4 | Address strap pins |
| strap_bypass_i | input | 1 | High at sampling time forces address 0x18 |
| scl_i | input | 1 | SMBus clock line, asynchronous |
| sda_i | input | 1 | SMBus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 drives the open-drain SDA low |
| addr_match_o | output | 1 | One-cycle pulse on an address match |
| rw_dir_o | output | 1 | Direction bit of the matched byte, 1 = read |
| busy_o | output | 1 | High from a match until STOP |

## Verification
A repeated START can arrive while the shifter still holds a partial byte. The START must then clear the bit count and win over the capture that would otherwise continue. The bench provokes this by clocking four arbitrary bits, issuing a repeated START and then sending a matching byte. It judges the result by exactly one match pulse, the correct direction and an acknowledge in the ninth clock. A second case checks a matching byte clocked straight after a mismatch with no START in between; it must raise no pulse and no pull.

// File: rtl/smb_addr_pkg.sv
// Package: shared types for the strap-latched SMBus address matcher.
// Assumes: nothing beyond IEEE 1800-2017.
package smb_addr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // shifting address byte
        ST_EVAL,   // comparing captured byte
        ST_ACKW,   // matched, waiting for falling SCL to drive ACK
        ST_ACK,    // driving ACK through the ninth clock
        ST_HOLD,   // addressed, waiting for STOP or repeated START
        ST_SKIP    // not addressed, ignoring bus until START
    } addr_state_t;
endpackage

// File: rtl/smb_sync.sv
// Module: multi-bit multi-stage synchroniser for asynchronous bus lines.
// Assumes: each bit is independent; idle level of the lines is high, so
// the stages reset to all ones.
module smb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw inputs through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_strap_latch.sv
// Module: captures the strap pins once after reset and forms the address.
// Assumes: straps are stable around reset release; STRAP_W < ADDR_W.
module smb_strap_latch #(
    parameter int                STRAP_W   = 4,
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               bypass,
    output logic [ADDR_W-1:0]  dev_addr,
    output logic               ready
);
    localparam int PAD_W = ADDR_W - STRAP_W;

    // Latch the address in the first cycle after reset release only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready    <= 1'b0;
            dev_addr <= BASE_ADDR;
        end else if (!ready) begin
            ready    <= 1'b1;
            dev_addr <= bypass ? BASE_ADDR : BASE_ADDR + {{PAD_W{1'b0}}, strap};
        end
    end

    // R1: once latched, the address never moves until reset.
    a_r1_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (ready && $stable(dev_addr)));
endmodule

// File: rtl/smb_cond_detect.sv
// Module: finds START, STOP and SCL edges on synchronised bus lines.
// Assumes: inputs are already synchronised to clk.
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, sda_d;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign start    = scl_s & scl_d & sda_d & ~sda_s;
    assign stop     = scl_s & scl_d & ~sda_d & sda_s;
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/smb_addr_fsm.sv
// Module: shifts in the address byte, compares it, drives ACK, tracks busy.
// Assumes: clk oversamples SCL so that every SCL phase spans several
// cycles; the ACK is driven only while SCL is low.
module smb_addr_fsm
    import smb_addr_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              start,
    input  logic              stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    output logic              sda_pull,
    output logic              addr_match,
    output logic              rw_dir,
    output logic              busy
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    addr_state_t       state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;

    // Address phase sequencer: STOP first, then START, then the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bitcnt     <= '0;
            sda_pull   <= 1'b0;
            addr_match <= 1'b0;
            rw_dir     <= 1'b0;
            busy       <= 1'b0;
        end else begin
            addr_match <= 1'b0;
            if (stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                busy     <= 1'b0;
            end else if (start && ready) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == CNT_W'(BYTE_W - 1)) state <= ST_EVAL;
                        end
                    end
                    ST_EVAL: begin
                        if (shreg[BYTE_W-1:1] == dev_addr) begin
                            addr_match <= 1'b1;
                            rw_dir     <= shreg[0];
                            busy       <= 1'b1;
                            state      <= ST_ACKW;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                    ST_ACKW: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_HOLD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: the match indication lasts a single cycle.
    a_r10_match_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |=> !addr_match);

    // R9: a match is always reported as busy.
    a_r9_match_busy: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> busy);

    // R9: STOP clears busy in the next cycle.
    a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy);

    // R6: the ACK drive only changes while SCL is low.
    a_r6_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    // R7: no ACK is ever driven without a prior match.
    a_r7_pull_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> busy);
endmodule

// File: rtl/smb_strap_addr_match.sv
// Module: top of the strap-latched SMBus address matcher.
// Assumes: sda_i is the wired line level including this block's own pull;
// clk runs at least ~10x the SCL rate.
module smb_strap_addr_match #(
    parameter int                STRAP_W     = 4,
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 7'h18,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               strap_bypass_i,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    output logic               addr_match_o,
    output logic               rw_dir_o,
    output logic               busy_o
);
    logic [1:0]        lines_s;
    logic              scl_s, sda_s;
    logic              start, stop, scl_rise, scl_fall;
    logic [ADDR_W-1:0] dev_addr;
    logic              ready;

    smb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    smb_strap_latch #(.STRAP_W(STRAP_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_latch (
        .clk(clk), .rst_n(rst_n), .strap(strap_i), .bypass(strap_bypass_i),
        .dev_addr(dev_addr), .ready(ready)
    );

    smb_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    smb_addr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ready(ready), .dev_addr(dev_addr),
        .scl_s(scl_s), .sda_s(sda_s), .start(start), .stop(stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_pull(sda_pull_o), .addr_match(addr_match_o),
        .rw_dir(rw_dir_o), .busy(busy_o)
    );
endmodule

// File: tb/sim_smb_strap_addr_match.sv
`timescale 1ns/1ps
module sim_smb_strap_addr_match;
    localparam int Q = 4;  // clk cycles per quarter SCL bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] strap = 4'h0;
    logic       bypass = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull, addr_match, rw_dir, busy;
    logic       sda_line;

    int tests = 0;
    int fails = 0;
    int match_cnt = 0;
    int long_pulse = 0;
    logic last_rw = 1'b0;
    logic prev_match = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    smb_strap_addr_match u0 (
        .clk(clk), .rst_n(rst_n), .strap_i(strap), .strap_bypass_i(bypass),
        .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .addr_match_o(addr_match), .rw_dir_o(rw_dir), .busy_o(busy)
    );

    // Pulse monitor: counts match pulses and records their direction.
    always @(posedge clk) begin
        if (addr_match) begin
            match_cnt++;
            last_rw = rw_dir;
            if (prev_match) long_pulse++;
        end
        prev_match = addr_match;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [3:0] s, input logic bp);
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        strap = s; bypass = bp;
        wq(4);
        rst_n = 1'b1;
        wq(3);
        strap = ~s; bypass = ~bp;   // later pin changes must not matter (R1)
        wq(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    // Eight data bits MSB first, then the ninth clock with SDA released.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl_m = 1'b0; wq(2*Q);
    endtask

    task automatic xfer(input logic [7:0] b, input bit exp_m, input string tag);
        int   m0;
        logic ack;
        m0 = match_cnt;
        bus_start();
        send_byte(b, ack);
        chk((match_cnt - m0) == int'(exp_m), tag, match_cnt - m0, int'(exp_m));
        if (exp_m) chk(last_rw == b[0], "R4 direction", int'(last_rw), int'(b[0]));
        chk(ack == exp_m, exp_m ? "R6 ack driven" : "R7 no ack", int'(ack), int'(exp_m));
        chk(sda_pull == 1'b0, "R6 pull released", int'(sda_pull), 0);
        chk(busy == exp_m, "R9 busy before stop", int'(busy), int'(exp_m));
        bus_stop();
        chk(busy == 1'b0, "R9 busy after stop", int'(busy), 0);
    endtask

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic ack;
        int   m0;
        wq(3);
        chk(sda_pull == 0 && addr_match == 0 && busy == 0, "R9 reset state",
            int'({sda_pull, addr_match, busy}), 0);

        // Sweep: every strap value, bypass off and on, every address in range.
        for (int bp = 0; bp < 2; bp++) begin
            for (int s = 0; s < 16; s++) begin
                int exp_a;
                do_reset(4'(s), bp[0]);
                exp_a = 'h18 + (bp != 0 ? 0 : s);
                for (int a = 'h18; a <= 'h27; a++) begin
                    logic [7:0] b;
                    b = {7'(a), 1'(a ^ s)};
                    xfer(b, a == exp_a, bp != 0 ? "R3 R1 bypass match" : "R2 R1 strap match");
                end
            end
        end

        // Directed cases on address 0x1D (strap 5).
        do_reset(4'h5, 1'b0);

        // R5: bit-reversed byte of a matching address must not match.
        xfer(8'h5C, 1'b0, "R5 msb first");
        xfer(8'h3A, 1'b1, "R5 matching write byte");

        // R8: repeated START in the middle of a byte restarts capture.
        m0 = match_cnt;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'h3B, ack);
        chk((match_cnt - m0) == 1, "R8 restart match", match_cnt - m0, 1);
        chk(last_rw == 1'b1, "R8 read direction", int'(last_rw), 1);
        chk(ack == 1'b1, "R8 ack", int'(ack), 1);

        // R9: busy persists across a following byte and a repeated START.
        send_byte(8'h3A, ack);
        chk((match_cnt - m0) == 1, "R9 no pulse on data byte", match_cnt - m0, 1);
        chk(ack == 1'b0, "R9 no ack on data byte", int'(ack), 0);
        chk(busy == 1'b1, "R9 busy held", int'(busy), 1);
        bus_start();
        send_byte(8'h50, ack);
        chk(busy == 1'b1, "R9 busy across repeated start", int'(busy), 1);
        bus_stop();
        chk(busy == 1'b0, "R9 stop clears", int'(busy), 0);

        // R7: after a mismatch a matching byte without START is ignored.
        m0 = match_cnt;
        bus_start();
        send_byte(8'h40, ack);
        send_byte(8'h3A, ack);
        chk((match_cnt - m0) == 0, "R7 ignored until start", match_cnt - m0, 0);
        chk(ack == 1'b0, "R7 no ack after mismatch", int'(ack), 0);
        chk(busy == 1'b0, "R7 not busy", int'(busy), 0);
        bus_start();
        send_byte(8'h3A, ack);
        chk((match_cnt - m0) == 1, "R7 start re-arms", match_cnt - m0, 1);
        chk(ack == 1'b1, "R7 ack after new start", int'(ack), 1);
        bus_stop();

        chk(long_pulse == 0, "R10 single-cycle pulse", long_pulse, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule